// File: doc/BRIEF.md
# Exception Priority Resolver with Promotable Maskable Source

This block decides which one of many pending exception requests a processor core services next. Six non-maskable requests (two kinds of reset, a watchdog reset, an illegal-opcode trap, a software trap and an external non-maskable interrupt line) are ranked in a fixed order. Sixteen maskable peripheral requests are ranked by index by default. Each maskable request is gated by its own local enable and by the global interrupt mask bit. The core supplies its condition-code mask bits as inputs.

A small promotion register holds the index of one maskable source. That source moves ahead of all the other maskable sources, and the remaining fifteen keep their usual order among themselves. Writes to this register are accepted only while the global interrupt mask is set. The winner is registered once per clock as a valid flag, a 5-bit source identifier and a 16-bit vector address. The vector address depends only on the identifier, so promotion never changes which vector a source uses.

Top module: `exc_arbiter`

## Requirements
- R1: During reset and at the first clock edge after it, `win_valid`, `win_id` and `win_vector` are 0. The promotion register resets to 0, so the default maskable order is in force.
- R2: The non-maskable requests `nm_req[0]` through `nm_req[5]` take identifiers 0 to 5 and rank in index order, with bit 0 (power-on or external reset) highest. The remaining bits, in falling rank, are clock-monitor reset, watchdog reset, illegal-opcode trap, software trap and external non-maskable interrupt.
- R3: `nm_req[5]` counts as a request only while `x_mask` is 0.
- R4: Any counted non-maskable request beats every maskable request.
- R5: Maskable source k (bit k of `irq_pend`) is eligible only when `irq_en[k]` is 1 and `i_mask` is 0. Its identifier is 6+k.
- R6: Without promotion, the eligible maskable source with the lowest index wins.
- R7: When the source named by the promotion register is eligible, it wins over all other maskable sources. Otherwise the lowest eligible index wins.
- R8: A promoted source that is not enabled locally, or that is blocked by `i_mask`=1, is never selected.
- R9: A write (`prio_wr`=1) loads `prio_wdata` into the promotion register only if `i_mask` is 1 at that clock edge. Otherwise the write is ignored. A new value governs arbitration from the following edge onward.
- R10: `win_vector` equals 0xFFFE minus twice `win_id`, whether or not that source is promoted.
- R11: The outputs reflect the inputs sampled at the previous rising edge. `win_valid` is 0, and `win_id` and `win_vector` are 0, when no request counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nm_req | input | 6 | Non-maskable requests, bit 0 highest |
| x_mask | input | 1 | Mask for the non-maskable external interrupt (bit 5) |
| i_mask | input | 1 | Global maskable-interrupt mask |
| irq_pend | input | 16 | Maskable requests pending |
| irq_en | input | 16 | Local enables of maskable sources |
| prio_wr | input | 1 | Write strobe for the promotion register |
| prio_wdata | input | 4 | Index to promote |
| win_valid | output | 1 | A winner was selected |
| win_id | output | 5 | Winning source identifier |
| win_vector | output | 16 | Vector address of the winner |

## Verification
The bench uses random pending-request patterns at two densities. Sparse patterns expose ordering between a few sources. Dense patterns show whether the promoted index jumps the queue while its neighbours keep their order. Non-maskable requests are kept rare, so that maskable arbitration dominates the run, while still testing that they always preempt. The `x_mask` and `i_mask` toggles show gating apart from ordering. Promotion writes made with `i_mask` clear are checked through later arbitration results that would differ had the write landed. Directed cases cover a promoted but locally disabled source and the full ladder of non-maskable requests.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
   localparam int NM_COUNT = 6;
   typedef enum logic [2:0] {
      NM_POWER_RST = 3'd0,
      NM_CLKMON    = 3'd1,
      NM_WDOG      = 3'd2,
      NM_ILLOP     = 3'd3,
      NM_SWTRAP    = 3'd4,
      NM_XLINE     = 3'd5
   } nm_src_e;
endpackage

// File: rtl/exc_first_pick.sv
// Lowest-index-wins search over a request vector.
module exc_first_pick #(
   parameter int N  = 6,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx
);
   generate
      if (N < 1 || (1 << IW) < N) begin : g_bad_cfg
         $error("exc_first_pick: index width too small");
      end
   endgenerate

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            valid = 1'b1;
            idx   = IW'(k);
         end
      end
   end
endmodule

// File: rtl/exc_promo_pick.sv
// Maskable arbitration: promoted index first, then lowest eligible index.
module exc_promo_pick #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]  elig,
   input  logic [IW-1:0] promo,
   output logic          valid,
   output logic [IW-1:0] idx
);
   logic          base_valid;
   logic [IW-1:0] base_idx;

   generate
      if ((1 << IW) != N) begin : g_bad_cfg
         $error("exc_promo_pick: N must equal 2**IW");
      end
   endgenerate

   exc_first_pick #(.N(N), .IW(IW)) u_base (
      .req  (elig),
      .valid(base_valid),
      .idx  (base_idx)
   );

   always_comb begin
      valid = base_valid;
      idx   = base_idx;
      if (elig[promo]) idx = promo;
   end
endmodule

// File: rtl/exc_prio_reg.sv
// Promotion register: writable only while maskable interrupts are inhibited.
module exc_prio_reg #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          i_mask,
   input  logic          wr,
   input  logic [IW-1:0] wdata,
   output logic [IW-1:0] prio_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               prio_q <= '0;
      else if (wr && i_mask)    prio_q <= wdata;
   end

   // R9: with interrupts unmasked the register cannot move
   assert_prio_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !i_mask |=> $stable(prio_q));
endmodule

// File: rtl/exc_vec_lut.sv
// Fixed vector table, computed from the identifier.
module exc_vec_lut #(
   parameter int          NUM_ID = 22,
   parameter int          IDW    = 5,
   parameter int          VW     = 16,
   parameter logic [15:0] TOP    = 16'hFFFE
) (
   input  logic [IDW-1:0] id,
   output logic [VW-1:0]  vec
);
   localparam int SLOTS = 1 << IDW;
   logic [VW-1:0] tbl [SLOTS];

   generate
      if (NUM_ID > SLOTS) begin : g_bad_cfg
         $error("exc_vec_lut: too many identifiers");
      end
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         if (g < NUM_ID) begin : g_used
            assign tbl[g] = VW'(int'(TOP) - 2 * g);
         end else begin : g_spare
            assign tbl[g] = '0;
         end
      end
   endgenerate

   assign vec = tbl[id];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
   parameter int          N_MASK   = 16,
   parameter int          VEC_W    = 16,
   parameter logic [15:0] VEC_TOP  = 16'hFFFE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [5:0]            nm_req,
   input  logic                  x_mask,
   input  logic                  i_mask,
   input  logic [N_MASK-1:0]     irq_pend,
   input  logic [N_MASK-1:0]     irq_en,
   input  logic                  prio_wr,
   input  logic [$clog2(N_MASK)-1:0] prio_wdata,
   output logic                  win_valid,
   output logic [$clog2(exc_arb_pkg::NM_COUNT + N_MASK)-1:0] win_id,
   output logic [VEC_W-1:0]      win_vector
);
   import exc_arb_pkg::*;

   localparam int IW     = $clog2(N_MASK);
   localparam int NUM_ID = NM_COUNT + N_MASK;
   localparam int IDW    = $clog2(NUM_ID);
   localparam int NMW    = $clog2(NM_COUNT);

   logic [NM_COUNT-1:0] nm_eff;
   logic [N_MASK-1:0]   elig;
   logic                nm_valid, mk_valid;
   logic [NMW-1:0]      nm_idx;
   logic [IW-1:0]       mk_idx, prio_q;
   logic                sel_valid;
   logic [IDW-1:0]      sel_id;
   logic [VEC_W-1:0]    sel_vec;

   assign nm_eff = {nm_req[NM_XLINE] & ~x_mask, nm_req[NM_SWTRAP:NM_POWER_RST]};
   assign elig   = irq_pend & irq_en & {N_MASK{~i_mask}};

   exc_prio_reg #(.IW(IW)) u_prio (
      .clk(clk), .rst_n(rst_n), .i_mask(i_mask),
      .wr(prio_wr), .wdata(prio_wdata), .prio_q(prio_q)
   );

   exc_first_pick #(.N(NM_COUNT), .IW(NMW)) u_nm (
      .req(nm_eff), .valid(nm_valid), .idx(nm_idx)
   );

   exc_promo_pick #(.N(N_MASK), .IW(IW)) u_mk (
      .elig(elig), .promo(prio_q), .valid(mk_valid), .idx(mk_idx)
   );

   always_comb begin
      sel_valid = nm_valid | mk_valid;
      if (nm_valid)      sel_id = IDW'(nm_idx);
      else if (mk_valid) sel_id = IDW'(NM_COUNT) + IDW'(mk_idx);
      else               sel_id = '0;
   end

   exc_vec_lut #(.NUM_ID(NUM_ID), .IDW(IDW), .VW(VEC_W), .TOP(VEC_TOP)) u_vec (
      .id(sel_id), .vec(sel_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_valid  <= 1'b0;
         win_id     <= '0;
         win_vector <= '0;
      end else begin
         win_valid  <= sel_valid;
         win_id     <= sel_id;
         win_vector <= sel_valid ? sel_vec : '0;
      end
   end

   // R4: a hard request among bits 0..4 always yields a non-maskable winner
   assert_nm_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|nm_req[4:0]) |-> (win_valid && win_id < IDW'(NM_COUNT)));
   // R5: maskable winners only appear when I was clear
   assert_i_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_id >= IDW'(NM_COUNT)) |-> !$past(i_mask));
   // R3: the external non-maskable line wins only when X was clear
   assert_x_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_id == IDW'(NM_XLINE)) |-> !$past(x_mask));
   // R7: an eligible promoted source with no hard request wins
   assert_promo_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(nm_eff) == '0 && $past(elig[prio_q]))
      |-> (win_id == IDW'(NM_COUNT) + IDW'($past(prio_q))));
   // R11: no winner flag means quiet identifier and vector
   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |-> (win_id == '0 && win_vector == '0));
endmodule

// File: tb/exc_arbiter_test.sv
module exc_arbiter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  nm_req = '0;
   logic        x_mask = 1'b1;
   logic        i_mask = 1'b1;
   logic [15:0] irq_pend = '0;
   logic [15:0] irq_en = '0;
   logic        prio_wr = 1'b0;
   logic [3:0]  prio_wdata = '0;
   logic        win_valid;
   logic [4:0]  win_id;
   logic [15:0] win_vector;

   int checks = 0;
   int errors = 0;
   logic [3:0] model_prio = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   exc_arbiter uut (
      .clk(clk), .rst_n(rst_n), .nm_req(nm_req), .x_mask(x_mask),
      .i_mask(i_mask), .irq_pend(irq_pend), .irq_en(irq_en),
      .prio_wr(prio_wr), .prio_wdata(prio_wdata),
      .win_valid(win_valid), .win_id(win_id), .win_vector(win_vector)
   );

   function automatic logic [5:0] ref_pick(input logic [5:0] nm, input logic x,
                                           input logic i, input logic [15:0] p,
                                           input logic [15:0] e, input logic [3:0] pr);
      logic [5:0]  nmv;
      logic [15:0] el;
      nmv = {nm[5] & ~x, nm[4:0]};
      el  = p & e & {16{~i}};
      for (int k = 0; k < 6; k++) if (nmv[k]) return {1'b1, 5'(k)};
      if (el[pr]) return {1'b1, 5'(6 + int'(pr))};
      for (int k = 0; k < 16; k++) if (el[k]) return {1'b1, 5'(6 + k)};
      return 6'd0;
   endfunction

   function automatic logic [15:0] ref_vec(input logic v, input logic [4:0] id);
      return v ? 16'(32'hFFFE - 2 * int'(id)) : 16'h0;
   endfunction

   task automatic check(input string tag, input logic [5:0] exp);
      logic [15:0] ev;
      ev = ref_vec(exp[5], exp[4:0]);
      checks++;
      if (win_valid !== exp[5] || win_id !== exp[4:0] || win_vector !== ev) begin
         errors++;
         $display("FAIL %s: got v=%0b id=%0d vec=%h expected v=%0b id=%0d vec=%h",
                  tag, win_valid, win_id, win_vector, exp[5], exp[4:0], ev);
      end
   endtask

   // Drive at negedge, clock once, check at the next negedge.
   task automatic step(input string tag, input logic [5:0] nm, input logic x,
                       input logic i, input logic [15:0] p, input logic [15:0] e,
                       input logic wr, input logic [3:0] wd);
      logic [5:0] exp;
      nm_req = nm; x_mask = x; i_mask = i; irq_pend = p; irq_en = e;
      prio_wr = wr; prio_wdata = wd;
      @(posedge clk);
      exp = ref_pick(nm, x, i, p, e, model_prio);
      if (wr && i) model_prio = wd;
      @(negedge clk);
      check(tag, exp);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (2) @(negedge clk);
      check("R1 reset", 6'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 6'd0);

      // R2 ladder: drop the top request each time
      step("R2 all nm", 6'h3F, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 4'd0);
      step("R2 no reset", 6'h3E, 1'b0, 1'b0, '0, '0, 1'b0, 4'd0);
      step("R2 watchdog", 6'h3C, 1'b0, 1'b0, '0, '0, 1'b0, 4'd0);
      step("R2 illop", 6'h38, 1'b0, 1'b0, '0, '0, 1'b0, 4'd0);
      step("R2 swtrap", 6'h30, 1'b0, 1'b0, '0, '0, 1'b0, 4'd0);
      step("R3 xline open", 6'h20, 1'b0, 1'b1, '0, '0, 1'b0, 4'd0);
      step("R3 xline masked", 6'h20, 1'b1, 1'b0, 16'h0100, 16'h0100, 1'b0, 4'd0);
      step("R4 nm beats irq", 6'h10, 1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0, 4'd0);
      step("R5 I set blocks", 6'h00, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 4'd0);
      step("R5 local disable", 6'h00, 1'b1, 1'b0, 16'h0006, 16'h0004, 1'b0, 4'd0);
      step("R6 default order", 6'h00, 1'b1, 1'b0, 16'h8421, 16'hFFFF, 1'b0, 4'd0);
      step("R11 idle", 6'h00, 1'b1, 1'b0, '0, '0, 1'b0, 4'd0);
      // R9 ignored write while unmasked: promote 9 should not stick
      step("R9 write ignored", 6'h00, 1'b1, 1'b0, '0, '0, 1'b1, 4'd9);
      step("R9 order unchanged", 6'h00, 1'b1, 1'b0, 16'h0202, 16'hFFFF, 1'b0, 4'd0);
      // accepted write, then promotion visible
      step("R9 write accepted", 6'h00, 1'b1, 1'b1, '0, '0, 1'b1, 4'd9);
      step("R7 promoted wins", 6'h00, 1'b1, 1'b0, 16'h0203, 16'hFFFF, 1'b0, 4'd0);
      step("R7 rest keep order", 6'h00, 1'b1, 1'b0, 16'h000C, 16'hFFFF, 1'b0, 4'd0);
      step("R8 promoted disabled", 6'h00, 1'b1, 1'b0, 16'h0210, 16'hFDFF, 1'b0, 4'd0);
      step("R8 promoted I set", 6'h00, 1'b1, 1'b1, 16'h0200, 16'hFFFF, 1'b0, 4'd0);
      step("R10 vector promoted", 6'h00, 1'b1, 1'b0, 16'h0200, 16'h0200, 1'b0, 4'd0);

      // random mix: R2..R11 against the reference search
      for (int n = 0; n < 3000; n++) begin
         logic [5:0]  nm;
         logic [15:0] p;
         nm = (($urandom % 8) == 0) ? 6'($urandom) : 6'd0;
         p  = (($urandom % 2) == 0) ? 16'($urandom & $urandom & $urandom) : 16'($urandom);
         step("R7 random", nm, 1'($urandom), (($urandom % 4) == 0),
              p, 16'($urandom | $urandom), (($urandom % 4) == 0), 4'($urandom));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule